// File: doc/BRIEF.md
# Programmable Clock Output Channel

This block produces one programmable clock output from a choice of up to five timing sources. All sources arrive as single-cycle tick pulses that are synchronous to one system clock, so the whole channel lives in a single clock domain. A configuration register holds a source-select field and a three-bit power-of-two prescaler. While the channel is on, the output toggles every 2^(P-1) selected ticks, which gives a square wave with a period of 2^P ticks. A prescaler of zero makes the output repeat each selected tick, one cycle later.

Three register layouts are available through a parameter. The narrow layout has a 2-bit select and no extension. The extended layout adds a flag bit that reaches a fifth source. The wide layout has a 3-bit select. The configuration can be changed only while the channel is off. Writes that would use an illegal prescaler or a missing source are dropped whole. The channel reports a ready flag in a shared status word, at bit CHAN_ID+8, once its first full output period has completed.

Top module: `pclk_chan`

## Requirements
- R1: A synchronous active-low reset leaves the channel off, `clk_out` low, `status_word` zero, and `cfg_rdata` at 0x00.
- R2: Register fields by `LAYOUT`:
  - narrow (A): select in bits 1:0, prescaler in bits 4:2.
  - extended (B): as A, plus a source-extension flag in bit 7.
  - wide (C): select in bits 2:0, prescaler in bits 6:4.
  - `cfg_rdata` returns the last accepted write, with bits outside these fields read as 0.
- R3: A write whose prescaler field is 7, or whose effective source index is NUM_SRC (5) or more, is ignored entirely.
- R4: A write is ignored while the channel is on.
- R5: The effective source index equals the select field. In layout B, when the flag is set and the 2-bit select is zero, the index is 4. Ticks on any other source have no effect on the output.
- R6: With prescaler P from 1 to 6, `clk_out` toggles after every 2^(P-1) selected ticks, so its period is 2^P ticks.
- R7: With prescaler 0, `clk_out` is high for exactly the cycle that follows each selected tick.
- R8: Turning the channel on clears the tick counter and forces `clk_out` low in the same edge. A turn-on strobe while the channel is already on has no effect.
- R9: `status_word` bit CHAN_ID+8 rises in the edge that completes the first full output period, which is the falling toggle (or the first tick when P is 0). All other status bits stay 0.
- R10: A turn-off strobe clears `clk_out` and the ready bit at the next edge. When turn-on and turn-off strobes coincide, turn-off wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Last accepted configuration value |
| on_strobe | input | 1 | Turn the channel on |
| off_strobe | input | 1 | Turn the channel off |
| src_tick | input | NUM_SRC | One tick-enable pulse per source |
| clk_out | output | 1 | Divided output |
| status_word | output | STAT_W | Shared status word; ready at bit CHAN_ID+8 |

## Verification
The embedded assertions assume that tick pulses are single-cycle enables aligned to the system clock. They also assume that strobes and writes are held for one clock cycle and are never glitched between edges. The bench meets both by driving every input on the falling clock edge from a generator that emits a tick on the selected source every N cycles. The bench keeps N at 1 or more, and it always turns a channel off before it rewrites that channel's configuration. Because of this, the counter-bound property may rely on the prescaler staying fixed while the channel runs.

// File: rtl/pclk_pkg.sv
// Shared types and field decoding for the programmable clock channel.
// Assumes an 8-bit configuration register and a 3-bit prescaler.
package pclk_pkg;

    localparam int REG_W   = 8;
    localparam int PRES_W  = 3;
    localparam int IDX_W   = 3;
    localparam int PRES_MAX = 6;

    typedef enum logic [1:0] {
        LAY_A = 2'd0,
        LAY_B = 2'd1,
        LAY_C = 2'd2
    } layout_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [PRES_W-1:0] pres;
        logic              ok;
    } cfg_fields_t;

    // Bits that exist in a given layout; all others read back as zero.
    function automatic logic [REG_W-1:0] field_mask(layout_e lay);
        case (lay)
            LAY_C:   return 8'h77;
            LAY_B:   return 8'h9F;
            default: return 8'h1F;
        endcase
    endfunction

    // Extract effective source index and prescaler, and judge legality.
    function automatic cfg_fields_t decode(layout_e lay, logic [REG_W-1:0] v, int nsrc);
        cfg_fields_t f;
        if (lay == LAY_C) begin
            f.idx  = v[2:0];
            f.pres = v[6:4];
        end else begin
            f.idx  = {1'b0, v[1:0]};
            f.pres = v[4:2];
            if (lay == LAY_B && v[7] && v[1:0] == 2'b00)
                f.idx = 3'd4;
        end
        f.ok = (f.pres != 3'd7) && (int'(f.idx) < nsrc);
        return f;
    endfunction

endpackage

// File: rtl/pclk_cfg_reg.sv
// Configuration register for one channel. Accepts a write only while the
// channel is off and only when the decoded fields are legal; presents the
// decoded source index and prescaler of the stored value.
// Assumes cfg_we is a single-cycle strobe synchronous to clk.
module pclk_cfg_reg
    import pclk_pkg::*;
#(
    parameter layout_e LAYOUT  = LAY_C,
    parameter int      NUM_SRC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    input  logic              locked,
    output logic [REG_W-1:0]  rdata,
    output logic [IDX_W-1:0]  src_idx,
    output logic [PRES_W-1:0] pres
);

    localparam logic [REG_W-1:0] MASK = field_mask(LAYOUT);

    logic [REG_W-1:0] reg_q;
    cfg_fields_t      wr_f;
    cfg_fields_t      cur_f;

    // Decode the incoming write and the stored value.
    always_comb begin
        wr_f  = decode(LAYOUT, wdata, NUM_SRC);
        cur_f = decode(LAYOUT, reg_q, NUM_SRC);
    end

    // Store a legal write while the channel is off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (we && !locked && wr_f.ok)
            reg_q <= wdata & MASK;
    end

    assign rdata   = reg_q;
    assign src_idx = cur_f.idx;
    assign pres    = cur_f.pres;

    // R4
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && locked) |=> $stable(reg_q));

    // R3
    bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wr_f.ok) |=> $stable(reg_q));

endmodule

// File: rtl/pclk_src_sel.sv
// Source tick selector: forwards the tick of the chosen source.
// Assumes src_idx values at or above NUM_SRC never occur (filtered on write).
module pclk_src_sel
    import pclk_pkg::*;
#(
    parameter int NUM_SRC = 5
) (
    input  logic [NUM_SRC-1:0] ticks,
    input  logic [IDX_W-1:0]   src_idx,
    output logic               tick_sel
);

    logic [NUM_SRC-1:0] hit;

    // One match line per source.
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            assign hit[g] = ticks[g] && (int'(src_idx) == g);
        end
    endgenerate

    // Merge the match lines.
    assign tick_sel = |hit;

endmodule

// File: rtl/pclk_divider.sv
// Power-of-two divider with on/off control and a ready flag. Counts
// selected ticks, toggles the output each 2^(P-1) ticks, and passes ticks
// through one cycle later when P is zero.
// Assumes pres stays fixed while the channel is on.
module pclk_divider
    import pclk_pkg::*;
#(
    parameter int PRES_LIM = PRES_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_set,
    input  logic              on_clr,
    input  logic              tick,
    input  logic [PRES_W-1:0] pres,
    output logic              div_out,
    output logic              ready,
    output logic              running
);

    localparam int MAX_HALF = 1 << (PRES_LIM - 1);
    localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;
    logic             out_q;
    logic             rdy_q;
    logic             en_q;

    // Terminal count for the active prescaler.
    always_comb begin
        half_m1 = '0;
        for (int i = 1; i <= PRES_LIM; i++)
            if (int'(pres) == i)
                half_m1 = CNT_W'((1 << (i - 1)) - 1);
    end

    // Channel state, tick counter, output and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
            out_q <= 1'b0;
            rdy_q <= 1'b0;
        end else if (on_clr) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
            out_q <= 1'b0;
            rdy_q <= 1'b0;
        end else if (on_set && !en_q) begin
            en_q  <= 1'b1;
            cnt_q <= '0;
            out_q <= 1'b0;
        end else if (en_q) begin
            if (pres == '0) begin
                out_q <= tick;
                if (tick)
                    rdy_q <= 1'b1;
            end else if (tick) begin
                if (cnt_q == half_m1) begin
                    cnt_q <= '0;
                    out_q <= ~out_q;
                    if (out_q)
                        rdy_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign div_out = out_q;
    assign ready   = rdy_q;
    assign running = en_q;

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!out_q && !rdy_q));

    // R8
    start_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_set && !on_clr && !en_q) |=> (cnt_q == '0 && !out_q));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && pres != '0) |-> (cnt_q <= half_m1));

    // R10
    off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        on_clr |=> !en_q);

endmodule

// File: rtl/pclk_chan.sv
// Programmable clock output channel: configuration register, source
// selector and divider, plus placement of the ready flag in the shared
// status word. Assumes all source ticks are synchronous to clk.
module pclk_chan
    import pclk_pkg::*;
#(
    parameter layout_e LAYOUT  = LAY_C,
    parameter int      CHAN_ID = 0,
    parameter int      NUM_SRC = 5,
    parameter int      STAT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic                on_strobe,
    input  logic                off_strobe,
    input  logic [NUM_SRC-1:0]  src_tick,
    output logic                clk_out,
    output logic [STAT_W-1:0]   status_word
);

    localparam int RDY_BIT = CHAN_ID + 8;

    logic [IDX_W-1:0]  src_idx;
    logic [PRES_W-1:0] pres;
    logic              tick_sel;
    logic              ready;
    logic              running;

    pclk_cfg_reg #(
        .LAYOUT  (LAYOUT),
        .NUM_SRC (NUM_SRC)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .locked  (running),
        .rdata   (cfg_rdata),
        .src_idx (src_idx),
        .pres    (pres)
    );

    pclk_src_sel #(
        .NUM_SRC (NUM_SRC)
    ) u_sel (
        .ticks    (src_tick),
        .src_idx  (src_idx),
        .tick_sel (tick_sel)
    );

    pclk_divider #(
        .PRES_LIM (PRES_MAX)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_set  (on_strobe),
        .on_clr  (off_strobe),
        .tick    (tick_sel),
        .pres    (pres),
        .div_out (clk_out),
        .ready   (ready),
        .running (running)
    );

    // Place the ready flag at this channel's status bit.
    always_comb begin
        status_word          = '0;
        status_word[RDY_BIT] = ready;
    end

    // R9
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_word));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!clk_out && status_word == '0 && cfg_rdata == '0));

endmodule

// File: tb/pclk_chan_test.sv
// Bench for pclk_chan: a vector table of register writes walked by one
// loop, then directed tests of division, selection, ready and control.
module pclk_chan_test;
    import pclk_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [7:0] wdata = '0;
    logic [2:0] we = '0, on = '0, off = '0;
    logic [4:0] src_tick = '0;
    logic [4:0] tick_mask = '0;
    int         tick_gap = 1;
    int         phase = 0;
    int         errors = 0, checks = 0;
    bit         done = 0;

    wire [7:0]  rd_c, rd_a, rd_b;
    wire        out_c, out_a, out_b;
    wire [15:0] st_c, st_a, st_b;
    wire [2:0]  outs = {out_b, out_a, out_c};

    pclk_chan #(.LAYOUT(LAY_C), .CHAN_ID(0)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(we[0]), .cfg_wdata(wdata), .cfg_rdata(rd_c),
        .on_strobe(on[0]), .off_strobe(off[0]), .src_tick(src_tick),
        .clk_out(out_c), .status_word(st_c));
    pclk_chan #(.LAYOUT(LAY_A), .CHAN_ID(7)) uut_a (
        .clk(clk), .rst_n(rst_n), .cfg_we(we[1]), .cfg_wdata(wdata), .cfg_rdata(rd_a),
        .on_strobe(on[1]), .off_strobe(off[1]), .src_tick(src_tick),
        .clk_out(out_a), .status_word(st_a));
    pclk_chan #(.LAYOUT(LAY_B), .CHAN_ID(5)) uut_b (
        .clk(clk), .rst_n(rst_n), .cfg_we(we[2]), .cfg_wdata(wdata), .cfg_rdata(rd_b),
        .on_strobe(on[2]), .off_strobe(off[2]), .src_tick(src_tick),
        .clk_out(out_b), .status_word(st_b));

    // {wdata, expected C, expected B, expected A} after each write
    localparam logic [31:0] VEC [6] = '{
        32'h25_00_05_05, 32'h34_34_14_14, 32'h80_00_80_00,
        32'h1C_14_80_00, 32'h72_14_12_12, 32'h13_13_13_13
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Tick generator: selected sources pulse every tick_gap cycles.
    initial forever begin
        @(negedge clk);
        phase = phase + 1;
        src_tick = ((phase % tick_gap) == 0) ? tick_mask : 5'b0;
    end

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wdata = d; we = sel;
        @(negedge clk);
        we = '0;
    endtask

    task automatic strobe(input logic [2:0] s_on, input logic [2:0] s_off);
        on = s_on; off = s_off;
        @(negedge clk);
        on = '0; off = '0;
    endtask

    task automatic measure(input int w, output int per);
        logic p, c;
        bit found = 0;
        per = -1;
        p = outs[w];
        for (int n = 0; n < 400 && !found; n++) begin
            @(negedge clk); c = outs[w];
            if (c && !p) found = 1;
            p = c;
        end
        if (!found) return;
        for (int k = 1; k < 400 && per < 0; k++) begin
            @(negedge clk); c = outs[w];
            if (c && !p) per = k;
            p = c;
        end
    endtask

    task automatic count_rises(input int w, input int cyc, output int cnt);
        logic p, c;
        cnt = 0;
        p = outs[w];
        for (int n = 0; n < cyc; n++) begin
            @(negedge clk); c = outs[w];
            if (c && !p) cnt++;
            p = c;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int per, cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rdata", rd_c, 0);
        chk("R1 clk_out", out_c, 0);
        chk("R1 status", st_c, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3: vector table on all three layouts
        foreach (VEC[i]) begin
            wr(3'b111, VEC[i][31:24]);
            chk($sformatf("R2 R3 vec%0d layout C", i), rd_c, VEC[i][23:16]);
            chk($sformatf("R2 R3 vec%0d layout B", i), rd_b, VEC[i][15:8]);
            chk($sformatf("R2 R3 vec%0d layout A", i), rd_a, VEC[i][7:0]);
        end

        // R9 R6: C, source 0, prescaler 2, tick every cycle
        wr(3'b001, 8'h20);
        tick_mask = 5'b00001; tick_gap = 1;
        strobe(3'b001, 3'b000);
        repeat (3) @(negedge clk);
        chk("R9 ready not yet", st_c, 16'h0000);
        @(negedge clk);
        chk("R9 ready after first period", st_c, 16'h0100);
        measure(0, per);
        chk("R6 period P=2", per, 4);

        // R8: second turn-on while running has no effect on the period
        strobe(3'b001, 3'b000);
        measure(0, per);
        chk("R8 period kept", per, 4);

        // R4: write while running is ignored
        wr(3'b001, 8'h00);
        chk("R4 locked write", rd_c, 8'h20);

        // R10: coincident on and off, off wins
        strobe(3'b001, 3'b001);
        chk("R10 out cleared", out_c, 0);
        chk("R10 ready cleared", st_c, 0);
        count_rises(0, 20, cnt);
        chk("R10 stays off", cnt, 0);

        // R7: prescaler 0 pass-through on source 3, tick every 3 cycles
        wr(3'b001, 8'h03);
        tick_mask = 5'b01000; tick_gap = 3;
        strobe(3'b001, 3'b000);
        measure(0, per);
        chk("R7 pass-through period", per, 3);
        count_rises(0, 30, cnt);
        chk("R7 one pulse per tick", cnt, 10);
        strobe(3'b000, 3'b001);

        // R6: C, source 4, prescaler 3, tick every 2 cycles
        wr(3'b001, 8'h34);
        tick_mask = 5'b10000; tick_gap = 2;
        strobe(3'b001, 3'b000);
        measure(0, per);
        chk("R6 period P=3 gap2", per, 16);
        strobe(3'b000, 3'b001);

        // R6 R9: A, source 2, prescaler 1
        wr(3'b010, 8'h06);
        tick_mask = 5'b00100; tick_gap = 1;
        strobe(3'b010, 3'b000);
        measure(1, per);
        chk("R6 layout A period P=1", per, 2);
        chk("R9 layout A ready bit 15", st_a, 16'h8000);
        strobe(3'b000, 3'b010);
        chk("R10 layout A ready cleared", st_a, 0);

        // R5: B, extension flag selects source 4
        wr(3'b100, 8'h88);
        chk("R2 layout B flag readback", rd_b, 8'h88);
        tick_mask = 5'b10000;
        strobe(3'b100, 3'b000);
        measure(2, per);
        chk("R5 source 4 via flag", per, 4);
        chk("R9 layout B ready bit 13", st_b, 16'h2000);
        strobe(3'b000, 3'b100);
        tick_mask = 5'b00001;
        strobe(3'b100, 3'b000);
        count_rises(2, 40, cnt);
        chk("R5 source 0 ignored", cnt, 0);
        strobe(3'b000, 3'b100);

        done = 1;
        summary();
        $finish;
    end

endmodule